// File: doc/BRIEF.md
# CAN Error-State Interrupt Flags

This block sits beside the error counters of a CAN controller node. It takes the live transmit and receive error counts as inputs and derives the node's fault-confinement state: error-active, error-passive or bus-off. It raises three sticky interrupt flags from that state and those counts: bus-off, error-passive and receive-error warning. Error-counter arithmetic, frame decoding and bit timing are handled elsewhere.

While the node is in bus-off, the block watches the sampled receive bits. It counts runs of eleven consecutive recessive bits. After 128 such runs the node returns to error-active. The bus-off flag is raised both when bus-off is entered and when it is left. Software must read the state register to tell which of the two happened.

Software reaches the block through a small register port. It clears flags by writing ones, and a mask register selects which flags drive the interrupt line.

Top module: `can_err_irq`

## Requirements
- R1: After reset, every flag reads 0, the mask reads 0, the node state is error-active (code 0) and `irq` is low.
- R2: The node state is output on `node_state` and also readable at address 2, bits [1:0]. The codes are 0 = error-active, 1 = error-passive, 2 = bus-off. The state updates on the clock edge that samples the counts. Outside bus-off, TEC ≥ 256 selects bus-off. Otherwise TEC ≥ 128 or REC ≥ 128 selects error-passive, and anything else selects error-active.
- R3: The bus-off flag (address 0, bit 6) is set on the same edge at which the node enters bus-off.
- R4: In bus-off, a bit with `bit_valid` high and `rx_bit`=1 (recessive) extends the current run. A bit with `bit_valid` high and `rx_bit`=0 restarts the run. Cycles with `bit_valid` low are ignored. On the 128th completed run of 11 bits, the node returns to error-active and the bus-off flag is set. Bits outside bus-off are not counted, and each entry into bus-off starts both counts from zero. While in bus-off, the TEC value is ignored.
- R5: The error-passive flag (address 0, bit 5) is set when the condition (TEC ≥ 128 or REC ≥ 128) rises.
- R6: The warning flag (address 0, bit 4) is set when REC ≥ 96 rises.
- R7: Writing 1 to a flag bit at address 0 clears that flag, and writing 0 leaves it unchanged. A flag cleared while its condition persists stays clear until the condition falls and rises again. Clearing a flag does not change the node state.
- R8: If a set and a write-1 clear of the same flag fall in one cycle, the flag ends up set.
- R9: The mask register sits at address 1, bits 6:4, in the same bit order as the flags, and reads back as written. `irq` is high when any flag is set whose mask bit is 0.
- R10: Flags stay set after their triggering condition goes away.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tec | input | 9 | Transmit error count |
| rec | input | 9 | Receive error count |
| rx_bit | input | 1 | Sampled receive bit, 1 = recessive |
| bit_valid | input | 1 | One-cycle strobe marking a sampled bit |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address: 0 flags, 1 mask, 2 state |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr` (combinational) |
| irq | output | 1 | Interrupt request |
| node_state | output | 2 | Fault-confinement state code |

## Verification
A hardware set of a flag and a software write-1 clear of that same flag can land in the same cycle. The bench forces this collision twice. First, the bit that completes the 128th recessive run is strobed in the same cycle as a write of 0x40. Second, TEC jumps from 0 to 300 in the same cycle as that write. In both cases the flags are read back afterwards, and bit 6 must be set; the error-passive bit is judged in the same read.

// File: rtl/can_err_pkg.sv
package can_err_pkg;

    typedef enum logic [1:0] {
        NODE_ACTIVE  = 2'd0,
        NODE_PASSIVE = 2'd1,
        NODE_BUSOFF  = 2'd2
    } node_st_e;

    // flag order inside the three-bit vector
    localparam int NFLG     = 3;
    localparam int FLG_WARN = 0;
    localparam int FLG_PAS  = 1;
    localparam int FLG_BO   = 2;
    localparam int FLG_LSB  = 4;   // register bit of FLG_WARN

    localparam logic [1:0] ADDR_FLAG = 2'd0;
    localparam logic [1:0] ADDR_MASK = 2'd1;
    localparam logic [1:0] ADDR_STAT = 2'd2;

endpackage

// File: rtl/can_err_state.sv
module can_err_state
    import can_err_pkg::*;
#(
    parameter int CNT_W    = 9,
    parameter int PAS_LIM  = 128,
    parameter int WARN_LIM = 96,
    parameter int BO_LIM   = 256,
    parameter int RUN_LEN  = 11,
    parameter int SEQ_NUM  = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] tec,
    input  logic [CNT_W-1:0] rec,
    input  logic             rx_bit,
    input  logic             bit_valid,
    output logic [1:0]       node_st,
    output logic             bo_evt,
    output logic             pas_cond,
    output logic             warn_cond
);

    localparam int RUN_W = $clog2(RUN_LEN + 1);
    localparam int SEQ_W = $clog2(SEQ_NUM + 1);
    localparam logic [CNT_W-1:0] PAS_C  = CNT_W'(PAS_LIM);
    localparam logic [CNT_W-1:0] WARN_C = CNT_W'(WARN_LIM);
    localparam logic [CNT_W-1:0] BO_C   = CNT_W'(BO_LIM);
    localparam logic [RUN_W-1:0] RUN_END = RUN_W'(RUN_LEN - 1);
    localparam logic [SEQ_W-1:0] SEQ_END = SEQ_W'(SEQ_NUM - 1);

    typedef struct packed {
        node_st_e         st;
        logic [RUN_W-1:0] run;
        logic [SEQ_W-1:0] seq;
    } st_regs_t;

    st_regs_t st_d, st_q;
    logic     evt_d;

    assign pas_cond  = (tec >= PAS_C) || (rec >= PAS_C);
    assign warn_cond = (rec >= WARN_C);

    always_comb begin
        st_d  = st_q;
        evt_d = 1'b0;
        if (st_q.st == NODE_BUSOFF) begin
            if (bit_valid) begin
                if (!rx_bit) begin
                    st_d.run = '0;
                end else if (st_q.run == RUN_END) begin
                    st_d.run = '0;
                    if (st_q.seq == SEQ_END) begin
                        st_d.seq = '0;
                        st_d.st  = NODE_ACTIVE;
                        evt_d    = 1'b1;
                    end else begin
                        st_d.seq = st_q.seq + 1'b1;
                    end
                end else begin
                    st_d.run = st_q.run + 1'b1;
                end
            end
        end else if (tec >= BO_C) begin
            st_d.st  = NODE_BUSOFF;
            st_d.run = '0;
            st_d.seq = '0;
            evt_d    = 1'b1;
        end else if (pas_cond) begin
            st_d.st = NODE_PASSIVE;
        end else begin
            st_d.st = NODE_ACTIVE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{st: NODE_ACTIVE, run: '0, seq: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign node_st = st_q.st;
    assign bo_evt  = evt_d;

endmodule

// File: rtl/can_err_flags.sv
module can_err_flags
    import can_err_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bo_evt,
    input  logic            pas_cond,
    input  logic            warn_cond,
    input  logic            wr_en,
    input  logic [1:0]      addr,
    input  logic [NFLG-1:0] wr_bits,
    output logic [NFLG-1:0] flag_vec,
    output logic [NFLG-1:0] mask_vec,
    output logic            irq
);

    typedef struct packed {
        logic [NFLG-1:0] flg;
        logic [NFLG-1:0] msk;
        logic            pas_prev;
        logic            warn_prev;
    } flg_regs_t;

    flg_regs_t       fl_d, fl_q;
    logic [NFLG-1:0] set_v;
    logic [NFLG-1:0] clr_v;
    logic [NFLG-1:0] flg_nxt;

    assign set_v[FLG_BO]   = bo_evt;
    assign set_v[FLG_PAS]  = pas_cond  & ~fl_q.pas_prev;
    assign set_v[FLG_WARN] = warn_cond & ~fl_q.warn_prev;
    assign clr_v = (wr_en && addr == ADDR_FLAG) ? wr_bits : '0;

    // a set in the same cycle overrides the clear
    for (genvar g = 0; g < NFLG; g++) begin : g_flag
        assign flg_nxt[g] = set_v[g] | (fl_q.flg[g] & ~clr_v[g]);
    end

    always_comb begin
        fl_d           = fl_q;
        fl_d.flg       = flg_nxt;
        fl_d.pas_prev  = pas_cond;
        fl_d.warn_prev = warn_cond;
        if (wr_en && addr == ADDR_MASK) begin
            fl_d.msk = wr_bits;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fl_q <= '0;
        end else begin
            fl_q <= fl_d;
        end
    end

    assign flag_vec = fl_q.flg;
    assign mask_vec = fl_q.msk;
    assign irq      = |(fl_q.flg & ~fl_q.msk);

endmodule

// File: rtl/can_err_irq.sv
module can_err_irq
    import can_err_pkg::*;
#(
    parameter int CNT_W    = 9,
    parameter int PAS_LIM  = 128,
    parameter int WARN_LIM = 96,
    parameter int BO_LIM   = 256,
    parameter int RUN_LEN  = 11,
    parameter int SEQ_NUM  = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] tec,
    input  logic [CNT_W-1:0] rec,
    input  logic             rx_bit,
    input  logic             bit_valid,
    input  logic             wr_en,
    input  logic [1:0]       addr,
    input  logic [7:0]       wr_data,
    output logic [7:0]       rd_data,
    output logic             irq,
    output logic [1:0]       node_state
);

    logic            bo_evt;
    logic            pas_cond;
    logic            warn_cond;
    logic [NFLG-1:0] flag_vec;
    logic [NFLG-1:0] mask_vec;

    logic unused_wr_bits;
    assign unused_wr_bits = &{1'b0, wr_data[7], wr_data[FLG_LSB-1:0]};

    can_err_state #(
        .CNT_W   (CNT_W),
        .PAS_LIM (PAS_LIM),
        .WARN_LIM(WARN_LIM),
        .BO_LIM  (BO_LIM),
        .RUN_LEN (RUN_LEN),
        .SEQ_NUM (SEQ_NUM)
    ) i_state (
        .clk      (clk),
        .rst_n    (rst_n),
        .tec      (tec),
        .rec      (rec),
        .rx_bit   (rx_bit),
        .bit_valid(bit_valid),
        .node_st  (node_state),
        .bo_evt   (bo_evt),
        .pas_cond (pas_cond),
        .warn_cond(warn_cond)
    );

    can_err_flags i_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .bo_evt   (bo_evt),
        .pas_cond (pas_cond),
        .warn_cond(warn_cond),
        .wr_en    (wr_en),
        .addr     (addr),
        .wr_bits  (wr_data[FLG_LSB +: NFLG]),
        .flag_vec (flag_vec),
        .mask_vec (mask_vec),
        .irq      (irq)
    );

    always_comb begin
        rd_data = '0;
        case (addr)
            ADDR_FLAG: rd_data[FLG_LSB +: NFLG] = flag_vec;
            ADDR_MASK: rd_data[FLG_LSB +: NFLG] = mask_vec;
            ADDR_STAT: rd_data[1:0]             = node_state;
            default:   rd_data                  = '0;
        endcase
    end

endmodule

// File: rtl/can_err_irq_chk.sv
module can_err_irq_chk
    import can_err_pkg::*;
#(
    parameter int CNT_W    = 9,
    parameter int PAS_LIM  = 128,
    parameter int WARN_LIM = 96,
    parameter int BO_LIM   = 256
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] tec,
    input logic [CNT_W-1:0] rec,
    input logic             wr_en,
    input logic [1:0]       addr,
    input logic [7:0]       wr_data,
    input logic [1:0]       node_state,
    input logic             irq,
    input logic [NFLG-1:0]  flag_vec,
    input logic [NFLG-1:0]  mask_vec,
    input logic             bo_evt,
    input logic             warn_cond
);

    localparam logic [CNT_W-1:0] PAS_C = CNT_W'(PAS_LIM);
    localparam logic [CNT_W-1:0] BO_C  = CNT_W'(BO_LIM);

    AST_STATE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        node_state != 2'd3); // R2

    AST_BUSOFF_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (node_state != NODE_BUSOFF && tec >= BO_C) |=> node_state == NODE_BUSOFF); // R2

    AST_PASSIVE_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (node_state != NODE_BUSOFF && tec < BO_C && (tec >= PAS_C || rec >= PAS_C))
        |=> node_state == NODE_PASSIVE); // R2

    AST_BUSOFF_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        node_state == NODE_BUSOFF |=> (node_state == NODE_BUSOFF || node_state == NODE_ACTIVE)); // R4

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        bo_evt |=> flag_vec[FLG_BO]); // R8

    AST_WARN_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(warn_cond) |=> flag_vec[FLG_WARN]); // R6

    for (genvar k = 0; k < NFLG; k++) begin : g_clr
        AST_CLEAR_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(flag_vec[k]) |-> $past(wr_en && addr == ADDR_FLAG && wr_data[FLG_LSB + k])); // R7
    end

    AST_MASK_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask_vec) |-> !irq); // R9

endmodule

bind can_err_irq can_err_irq_chk #(
    .CNT_W   (CNT_W),
    .PAS_LIM (PAS_LIM),
    .WARN_LIM(WARN_LIM),
    .BO_LIM  (BO_LIM)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tec       (tec),
    .rec       (rec),
    .wr_en     (wr_en),
    .addr      (addr),
    .wr_data   (wr_data),
    .node_state(node_state),
    .irq       (irq),
    .flag_vec  (flag_vec),
    .mask_vec  (mask_vec),
    .bo_evt    (bo_evt),
    .warn_cond (warn_cond)
);

// File: tb/test_can_err_irq.sv
`timescale 1ns/100ps
module test_can_err_irq;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [8:0] tec = '0;
    logic [8:0] rec = '0;
    logic       rx_bit = 1'b1;
    logic       bit_valid = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       irq;
    logic [1:0] node_state;

    int errs = 0;
    int checks = 0;

    always #2 clk = ~clk;   // 250 MHz

    can_err_irq i_can_err_irq (
        .clk(clk), .rst_n(rst_n), .tec(tec), .rec(rec), .rx_bit(rx_bit),
        .bit_valid(bit_valid), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .irq(irq), .node_state(node_state)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        addr = a;
        #0.2;
        d = rd_data;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; addr = a; wr_data = d;
        tick();
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic chk_flags(input string req, input int exp);
        logic [7:0] d;
        rd(2'd0, d);
        check({req, " flags"}, int'(d[6:4]), exp);
    endtask

    task automatic chk_state(input string req, input int exp);
        logic [7:0] d;
        rd(2'd2, d);
        check({req, " state reg"}, int'(d[1:0]), exp);
        check({req, " state port"}, int'(node_state), exp);
    endtask

    task automatic send_bits(input int n, input logic b);
        for (int i = 0; i < n; i++) begin
            rx_bit = b; bit_valid = 1'b1;
            tick();
            bit_valid = 1'b0; rx_bit = 1'b1;
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errs, checks);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog act=running exp=finished");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] d;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1 reset state
        chk_flags("R1", 0);
        rd(2'd1, d); check("R1 mask", int'(d), 0);
        chk_state("R1", 0);
        check("R1 irq", int'(irq), 0);

        // R2 R5 R6 R9: REC sweep with TEC at 0
        for (int r = 0; r <= 300; r++) begin
            rec = 9'(r > 511 ? 511 : (r > 300 ? 300 : r));
            if (r > 260) rec = 9'd260;
            tick();
            chk_state("R2 rec sweep", (r >= 128) ? 1 : 0);
            chk_flags("R5 R6 rec sweep", ((r >= 128) ? 2 : 0) + ((r >= 96) ? 1 : 0));
            check("R9 irq rec sweep", int'(irq), (r >= 96) ? 1 : 0);
        end

        // R10 flags stay latched
        rec = '0;
        tick(); tick();
        chk_flags("R10", 3);
        chk_state("R10", 0);

        // R7 writing zeros has no effect
        wr(2'd0, 8'h00);
        chk_flags("R7 zero write", 3);
        wr(2'd0, 8'h8F);
        chk_flags("R7 outside bits", 3);

        // R7 clear while condition persists
        rec = 9'd200;
        tick();
        wr(2'd0, 8'h10);
        chk_flags("R7 clear warn", 2);
        tick(); tick();
        chk_flags("R7 no re-set", 2);
        wr(2'd0, 8'h20);
        chk_flags("R7 clear passive", 0);
        chk_state("R7 state kept", 1);
        rec = 9'd50; tick();
        rec = 9'd100; tick();
        chk_flags("R6 new entry", 1);
        chk_state("R2 rec 100", 0);
        rec = '0;
        wr(2'd0, 8'h70);

        // R2 R5 TEC sweep
        for (int t = 0; t <= 255; t++) begin
            tec = 9'(t);
            tick();
            chk_state("R2 tec sweep", (t >= 128) ? 1 : 0);
            chk_flags("R5 tec sweep", (t >= 128) ? 2 : 0);
        end
        tec = 9'd256;
        tick();
        chk_state("R3 enter", 2);
        chk_flags("R3 enter", 6);

        // R9 mask sweep with flags 110
        for (int m = 0; m < 8; m++) begin
            wr(2'd1, 8'(m << 4));
            rd(2'd1, d);
            check("R9 mask readback", int'(d), m << 4);
            check("R9 irq masked", int'(irq), ((6 & ~m) != 0) ? 1 : 0);
        end
        wr(2'd1, 8'h00);

        // R4 recovery
        wr(2'd0, 8'h40);
        tec = 9'd300; tick();
        chk_flags("R3 no re-entry", 2);
        tec = '0; tick();
        chk_state("R4 tec ignored", 2);
        send_bits(10, 1'b1);
        send_bits(1, 1'b0);              // restarts the run
        send_bits(5, 1'b1);
        rx_bit = 1'b0; tick(); rx_bit = 1'b1;  // no strobe: ignored
        send_bits(6, 1'b1);              // run 1 done
        send_bits(126 * 11, 1'b1);       // runs 2..127
        send_bits(10, 1'b1);
        chk_state("R4 one bit short", 2);
        chk_flags("R4 one bit short", 2);
        // R8 last recessive bit together with a clear of bit 6
        rx_bit = 1'b1; bit_valid = 1'b1;
        wr_en = 1'b1; addr = 2'd0; wr_data = 8'h40;
        tick();
        bit_valid = 1'b0; wr_en = 1'b0; wr_data = '0;
        chk_state("R4 recovered", 0);
        chk_flags("R8 set wins on exit", 6);

        // R4 bits outside bus-off are not counted
        send_bits(40, 1'b1);
        chk_state("R4 active stays", 0);
        wr(2'd0, 8'h70);
        chk_flags("R7 clear all", 0);

        // R8 entry together with a clear of bit 6
        tec = 9'd300;
        wr_en = 1'b1; addr = 2'd0; wr_data = 8'h40;
        tick();
        wr_en = 1'b0; wr_data = '0;
        chk_state("R3 enter again", 2);
        chk_flags("R8 set wins on entry", 6);
        tec = '0;

        // R4 second recovery needs the full count again
        wr(2'd0, 8'h70);
        send_bits(128 * 11 - 1, 1'b1);
        chk_state("R4 second short", 2);
        chk_flags("R4 second short", 0);
        send_bits(1, 1'b1);
        chk_state("R4 second recovered", 0);
        chk_flags("R4 second recovered", 4);
        check("R9 irq bus-off flag", int'(irq), 1);

        summary();
        $finish;
    end

endmodule